// File: doc/BRIEF.md
# Late Data Cancellation Protocol Monitor

This block sits beside a processor bus master and watches the system side of its data handshake. The handshake has four low-true pins: transaction start, transfer acknowledge, data retry and address retry. The monitor checks that the system keeps to the rules for cancelling a data beat after that beat has been acknowledged. It does not drive the bus and does not touch the data.

Every clock edge during hard reset, the data-retry pin is sampled. The value taken at the last edge before reset is released selects the operating mode, and that mode is then held until the next reset. When data retry was negated, the block runs in normal mode. In that mode a beat acknowledged in one cycle may be cancelled in the next cycle by data retry or by address retry, and the monitor emits a one-cycle cancel pulse for each such beat. When data retry was asserted, the block runs in strict mode, where late cancellation is forbidden. Any data retry is then a violation. Address retry is also a violation once the first acknowledge of the current transaction has been seen, because address retry must arrive no later than that first acknowledge. Each violation class drives a one-cycle pulse and a sticky flag. The sticky flag is cleared by reset or by the clear input.

Transaction tracking uses a three-state machine. `TX_IDLE` is the state after reset, before any transaction start. `TX_AWAIT_ACK` means a start has been seen but no acknowledge yet. `TX_POST_ACK` means the first acknowledge of the transaction has been seen. The transitions are as follows. A start moves the machine from any state to `TX_AWAIT_ACK`. An acknowledge without a start moves `TX_AWAIT_ACK` to `TX_POST_ACK`. An acknowledge in `TX_IDLE` leaves the machine in `TX_IDLE`. In all other cases the machine keeps its state.

Top module: `ldc_monitor`

## Requirements
- R1: The data-retry pin level at the last clock edge with `rst_n` low sets `strict_mode`. Asserted gives 1 (strict). Negated gives 0 (normal).
- R2: After reset is released, `strict_mode` does not change, whatever the data-retry pin does.
- R3: In normal mode, if acknowledge is asserted in cycle c and data retry is asserted in cycle c+1, `cancel_pulse` is high for exactly the cycle after the edge that ends c+1.
- R4: In normal mode, if acknowledge is asserted in cycle c and address retry is asserted in cycle c+1, `cancel_pulse` is high in the same way as in R3.
- R5: `cancel_pulse` stays low when the cycle before the retry had no acknowledge. It is always low in strict mode.
- R6: In strict mode, data retry asserted in any cycle gives `dretry_viol_pulse` = 1 for one cycle after that edge, and sets `dretry_viol_flag`.
- R7: In strict mode, address retry in the cycle right after the first acknowledge of a transaction gives `aretry_viol_pulse` for one cycle and sets `aretry_viol_flag`.
- R8: In strict mode, the following are legal and raise nothing: address retry in the start cycle, address retry before the first acknowledge, address retry in the same cycle as the first acknowledge, and address retry together with a new start.
- R9: In strict mode, address retry in any later cycle after the first acknowledge, up to the next start, is also an address violation.
- R10: In normal mode no violation pulse or flag is ever raised.
- R11: A sticky flag stays set until reset, or until `clear` is sampled high with no new violation of that class in the same cycle. A new violation takes priority over `clear`.
- R12: While `rst_n` is low and after it is released, `cancel_pulse`, both violation pulses and both violation flags are 0.
- R13: With the default `ACTIVE_LOW` = 1, each handshake pin is asserted when low and negated when high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, low true. Mode is strapped while low |
| xfer_start_n | input | 1 | Transaction start pin |
| xfer_ack_n | input | 1 | Transfer acknowledge pin |
| data_retry_n | input | 1 | Data retry pin, also the mode strap |
| addr_retry_n | input | 1 | Address retry snoop pin |
| clear | input | 1 | High clears both sticky violation flags |
| strict_mode | output | 1 | 1 = late cancellation forbidden |
| cancel_pulse | output | 1 | One-cycle pulse for a legally cancelled beat |
| dretry_viol_pulse | output | 1 | One-cycle data-retry violation pulse |
| aretry_viol_pulse | output | 1 | One-cycle address-retry violation pulse |
| dretry_viol_flag | output | 1 | Sticky data-retry violation |
| aretry_viol_flag | output | 1 | Sticky address-retry violation |

## Verification
The bench builds the monitor with its default `ACTIVE_LOW` = 1, so every stimulus reaches the block through low-true pins and the boundary inversion is exercised on every check. A vector table run in normal mode covers cancels by either retry, retries that follow no acknowledge, and back-to-back acknowledges. Directed sequences after a strict-mode strap then cover the one-cycle window after the first acknowledge, later address retries, a start coinciding with a retry, and clear colliding with a new violation.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    typedef enum logic [1:0] {
        TX_IDLE      = 2'd0,
        TX_AWAIT_ACK = 2'd1,
        TX_POST_ACK  = 2'd2
    } txn_state_t;

    localparam int unsigned PIN_START  = 0;
    localparam int unsigned PIN_ACK    = 1;
    localparam int unsigned PIN_DRETRY = 2;
    localparam int unsigned PIN_ARETRY = 3;
    localparam int unsigned NUM_PINS   = 4;

    localparam int unsigned VIOL_DATA = 0;
    localparam int unsigned VIOL_ADDR = 1;
    localparam int unsigned NUM_VIOL  = 2;

endpackage

// File: rtl/ldc_pin_cond.sv
module ldc_pin_cond #(
    parameter int unsigned WIDTH      = 4,
    parameter bit          ACTIVE_LOW = 1'b1
) (
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] active_o
);

    generate
        if (ACTIVE_LOW) begin : g_invert
            assign active_o = ~pins_i;
        end else begin : g_pass
            assign active_o = pins_i;
        end
    endgenerate

endmodule

// File: rtl/ldc_mode_strap.sv
module ldc_mode_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic dretry_a,
    output logic strict_mode
);

    logic strict_q;

    // Loads on every edge while reset is held; the last one wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strict_q <= dretry_a;
        end
    end

    assign strict_mode = strict_q;

    // R2: mode frozen once reset has been released
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strict_mode));

endmodule

// File: rtl/ldc_txn_fsm.sv
module ldc_txn_fsm
    import ldc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_a,
    input  logic ack_a,
    output logic in_txn,
    output logic past_first_ack
);

    txn_state_t state_q;
    txn_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (start_a) state_d = TX_AWAIT_ACK;
            end
            TX_AWAIT_ACK: begin
                if (start_a)    state_d = TX_AWAIT_ACK;
                else if (ack_a) state_d = TX_POST_ACK;
            end
            TX_POST_ACK: begin
                if (start_a) state_d = TX_AWAIT_ACK;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        in_txn         = (state_q != TX_IDLE);
        past_first_ack = (state_q == TX_POST_ACK);
    end

    // R7: an acknowledge inside a transaction opens the post-ack window
    p_post_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_IDLE && ack_a && !start_a) |=> past_first_ack);

    // R8: a start always re-arms the wait for the first acknowledge
    p_start_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_a |=> (state_q == TX_AWAIT_ACK));

endmodule

// File: rtl/ldc_viol_flags.sv
module ldc_viol_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] event_i,
    output logic [N-1:0] pulse_o,
    output logic [N-1:0] flag_o
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pulse_o[i] <= 1'b0;
                    flag_o[i]  <= 1'b0;
                end else begin
                    pulse_o[i] <= event_i[i];
                    if (event_i[i])  flag_o[i] <= 1'b1;
                    else if (clr)    flag_o[i] <= 1'b0;
                end
            end

            // R11: a flag only drops after a clear request
            p_fall_needs_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flag_o[i]) |-> $past(clr));

            // R11: a pulse always leaves its flag set
            p_pulse_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_o[i] |-> flag_o[i]);
        end
    endgenerate

endmodule

// File: rtl/ldc_monitor.sv
module ldc_monitor
    import ldc_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start_n,
    input  logic xfer_ack_n,
    input  logic data_retry_n,
    input  logic addr_retry_n,
    input  logic clear,
    output logic strict_mode,
    output logic cancel_pulse,
    output logic dretry_viol_pulse,
    output logic aretry_viol_pulse,
    output logic dretry_viol_flag,
    output logic aretry_viol_flag
);

    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] act;
    logic                start_a, ack_a, dretry_a, aretry_a;
    logic                in_txn, past_first_ack;
    logic                ack_q, cancel_q;
    logic [NUM_VIOL-1:0] viol_ev, viol_pulse, viol_flag;

    always_comb begin
        pins             = '0;
        pins[PIN_START]  = xfer_start_n;
        pins[PIN_ACK]    = xfer_ack_n;
        pins[PIN_DRETRY] = data_retry_n;
        pins[PIN_ARETRY] = addr_retry_n;
    end

    ldc_pin_cond #(.WIDTH(NUM_PINS), .ACTIVE_LOW(ACTIVE_LOW)) u_pins (
        .pins_i   (pins),
        .active_o (act)
    );

    assign start_a  = act[PIN_START];
    assign ack_a    = act[PIN_ACK];
    assign dretry_a = act[PIN_DRETRY];
    assign aretry_a = act[PIN_ARETRY];

    ldc_mode_strap u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .dretry_a    (dretry_a),
        .strict_mode (strict_mode)
    );

    ldc_txn_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_a        (start_a),
        .ack_a          (ack_a),
        .in_txn         (in_txn),
        .past_first_ack (past_first_ack)
    );

    always_comb begin
        viol_ev            = '0;
        viol_ev[VIOL_DATA] = strict_mode && dretry_a;
        viol_ev[VIOL_ADDR] = strict_mode && aretry_a && past_first_ack && !start_a;
    end

    ldc_viol_flags #(.N(NUM_VIOL)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clear),
        .event_i (viol_ev),
        .pulse_o (viol_pulse),
        .flag_o  (viol_flag)
    );

    // Output process: late cancel of the previous beat in normal mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            cancel_q <= 1'b0;
        end else begin
            ack_q    <= ack_a;
            cancel_q <= !strict_mode && ack_q && (dretry_a || aretry_a);
        end
    end

    assign cancel_pulse      = cancel_q;
    assign dretry_viol_pulse = viol_pulse[VIOL_DATA];
    assign aretry_viol_pulse = viol_pulse[VIOL_ADDR];
    assign dretry_viol_flag  = viol_flag[VIOL_DATA];
    assign aretry_viol_flag  = viol_flag[VIOL_ADDR];

    p_cancel_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_a && !strict_mode) ##1 dretry_a |=> cancel_pulse);

    p_cancel_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_a && !strict_mode) ##1 aretry_a |=> cancel_pulse);

    p_no_cancel_strict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strict_mode |-> !cancel_pulse);

    p_data_viol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_mode && dretry_a) |=> dretry_viol_pulse);

    p_addr_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_mode && in_txn && ack_a && !start_a) ##1 (aretry_a && !start_a)
        |=> aretry_viol_pulse);

    p_quiet_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !strict_mode |-> !(dretry_viol_flag || aretry_viol_flag));

endmodule

// File: tb/sim_ldc_monitor.sv
module sim_ldc_monitor;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start_n = 1'b1, xfer_ack_n = 1'b1;
    logic data_retry_n = 1'b1, addr_retry_n = 1'b1;
    logic clear = 1'b0;
    logic strict_mode, cancel_pulse;
    logic dretry_viol_pulse, aretry_viol_pulse, dretry_viol_flag, aretry_viol_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ldc_monitor u0 (
        .clk(clk), .rst_n(rst_n),
        .xfer_start_n(xfer_start_n), .xfer_ack_n(xfer_ack_n),
        .data_retry_n(data_retry_n), .addr_retry_n(addr_retry_n),
        .clear(clear), .strict_mode(strict_mode), .cancel_pulse(cancel_pulse),
        .dretry_viol_pulse(dretry_viol_pulse), .aretry_viol_pulse(aretry_viol_pulse),
        .dretry_viol_flag(dretry_viol_flag), .aretry_viol_flag(aretry_viol_flag)
    );

    // {start, ack, dretry, aretry, clear, exp_cancel} in normal mode, active high
    localparam logic [5:0] VEC [13] = '{
        6'b10000_0,  // start
        6'b00000_0,  // idle
        6'b01000_0,  // ack
        6'b00100_1,  // R3 data retry after ack
        6'b01000_0,  // ack
        6'b00010_1,  // R4 address retry after ack
        6'b01000_0,  // ack
        6'b01000_0,  // R5 ack after ack, no retry
        6'b00000_0,
        6'b00100_0,  // R5 retry without prior ack
        6'b11000_0,  // start with ack
        6'b00110_1,  // R3/R4 both retries
        6'b00000_0
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ts, input logic ta, input logic dr,
                         input logic ar, input logic cl);
        xfer_start_n = ~ts;
        xfer_ack_n   = ~ta;
        data_retry_n = ~dr;
        addr_retry_n = ~ar;
        clear        = cl;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reset_into(input logic strict);
        rst_n = 1'b0;
        xfer_start_n = 1'b1; xfer_ack_n = 1'b1; addr_retry_n = 1'b1;
        data_retry_n = ~strict;
        clear = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        data_retry_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_flags(input string tag, input logic ed, input logic ea);
        check({tag, " data flag"}, dretry_viol_flag, ed);
        check({tag, " addr flag"}, aretry_viol_flag, ea);
    endtask

    initial begin
        // R12 during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R12 cancel in reset", cancel_pulse, 1'b0);
        check_flags("R12 in reset", 1'b0, 1'b0);

        // R1/R13: strap normal mode (pin high = negated)
        reset_into(1'b0);
        check("R1 normal strap", strict_mode, 1'b0);
        check("R12 cancel after reset", cancel_pulse, 1'b0);

        for (int i = 0; i < 13; i++) begin
            drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            check($sformatf("R3/R4/R5 row %0d cancel", i), cancel_pulse, VEC[i][0]);
            check($sformatf("R10 row %0d data pulse", i), dretry_viol_pulse, 1'b0);
            check($sformatf("R10 row %0d addr pulse", i), aretry_viol_pulse, 1'b0);
            check_flags($sformatf("R10 row %0d", i), 1'b0, 1'b0);
        end
        check("R2 normal mode held", strict_mode, 1'b0);

        // R1/R13: strap strict mode (pin low = asserted)
        reset_into(1'b1);
        check("R1 strict strap", strict_mode, 1'b1);
        check_flags("R12 strict after reset", 1'b0, 1'b0);

        drive(1, 0, 0, 1, 0);   // start with address retry
        check("R8 retry at start", aretry_viol_pulse, 1'b0);
        drive(0, 1, 0, 1, 0);   // first ack with address retry
        check("R8 retry with first ack", aretry_viol_pulse, 1'b0);
        drive(0, 0, 0, 1, 0);   // cycle right after first ack
        check("R7 retry after first ack pulse", aretry_viol_pulse, 1'b1);
        check_flags("R7", 1'b0, 1'b1);
        drive(0, 0, 0, 0, 0);
        check("R11 pulse one cycle", aretry_viol_pulse, 1'b0);
        check_flags("R11 sticky", 1'b0, 1'b1);
        drive(0, 0, 0, 1, 0);
        check("R9 later retry", aretry_viol_pulse, 1'b1);
        drive(0, 0, 0, 0, 1);
        check_flags("R11 clear", 1'b0, 1'b0);

        drive(1, 0, 0, 1, 0);   // new start with retry while past ack
        check("R8 retry with new start", aretry_viol_pulse, 1'b0);
        drive(0, 0, 0, 1, 0);   // before first ack
        check("R8 retry before ack", aretry_viol_pulse, 1'b0);
        drive(0, 1, 0, 0, 0);
        drive(0, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        check_flags("R8 no violation", 1'b0, 1'b0);
        drive(0, 0, 0, 1, 0);
        check("R9 retry two cycles after ack", aretry_viol_pulse, 1'b1);

        drive(0, 1, 0, 0, 0);
        drive(0, 0, 1, 0, 0);   // data retry after ack in strict mode
        check("R6 data retry pulse", dretry_viol_pulse, 1'b1);
        check("R5 no cancel in strict", cancel_pulse, 1'b0);
        check("R6 data flag", dretry_viol_flag, 1'b1);
        drive(0, 0, 1, 0, 1);   // clear colliding with new violation
        check("R11 violation beats clear", dretry_viol_flag, 1'b1);
        drive(0, 0, 0, 0, 1);
        check_flags("R11 clear both", 1'b0, 1'b0);
        drive(0, 0, 0, 0, 0);
        check("R2 strict held", strict_mode, 1'b1);

        // set a flag, then reset into normal mode
        drive(0, 0, 1, 0, 0);
        check("R6 flag before reset", dretry_viol_flag, 1'b1);
        reset_into(1'b0);
        check("R1 back to normal", strict_mode, 1'b0);
        check_flags("R12 reset clears", 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule